// File: doc/BRIEF.md
# Priority Interrupt Level Resolver

This block decides, once per clock, whether a level interrupt should be presented to the processor core, and with which trap type. It merges up to fifteen external interrupt level lines with a software pending register. It compares the result against the current processor priority and the global interrupt enable. It also takes into account any trap that is already being serviced and any vector interrupt that is waiting.

The software pending register has two timer-match bits: bit 0 for the cycle tick and bit 16 for the system tick. Neither one appears as a level of its own. Either of them raises level 14 instead. The winning level n is reported as trap type 0x040 | n on a 9-bit output, next to a request line. Both outputs are registered, so a change at the inputs is visible one clock later. The core holds the request until the resolver withdraws it or moves it to a different level.

Top module: `irq_level_resolver`

## Requirements
- R1: The pending mask is the bitwise OR of the external lines and bits [15:0] of the software register, with bit 0 (tick match) excluded. External line k (bit k of `ext_lvl`, k = 1..15) stands for level k.
- R2: When software bit 0 or bit 16 is set, level 14 is pending. Neither bit makes any other level pending.
- R3: While `vec_busy` is 1, `irq_req` and `irq_tt` keep their values, whatever the other inputs do.
- R4: When the pending mask, read as a number, is below 2 << `cur_prio`, the next clock sets `irq_req` to 0 and `irq_tt` to 0.
- R5: With interrupts enabled, the highest pending level n above `cur_prio` wins, and its trap type is 0x040 | n (bits [8:4] = 0x04, bits [3:0] = n).
- R6: The winner is not latched when three conditions hold together: `trap_lvl` is nonzero, `active_tt[8:4]` equals 0x04, and `active_tt` is strictly greater than the winner's trap type. In that case both outputs keep their values. A trap of another class, a zero trap level, or an equal trap type does not suppress the winner.
- R7: When the winner's trap type differs from the latched one, `irq_tt` takes the new value and `irq_req` is 1. This holds whether the new level is higher or lower. When the two are equal, nothing changes. `irq_req` is 1 exactly when `irq_tt` is nonzero.
- R8: When `int_en` is 0 and `vec_busy` is 0, the next clock sets `irq_req` and `irq_tt` to 0.
- R9: Asserting `rst_n` low clears `irq_req` and `irq_tt` at once, without waiting for a clock.
- R10: Outputs change only at a rising clock edge, one cycle after the inputs that cause the change.
- R11: With `cur_prio` = 15, no level can win, and the outputs are cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_lvl | input | 15 | External interrupt levels 15..1 |
| sw_pend | input | 17 | Software pending register (bit 0 tick match, bit 16 system-tick match) |
| cur_prio | input | 4 | Current processor interrupt priority |
| int_en | input | 1 | Global interrupt enable |
| trap_lvl | input | 3 | Current trap nesting level |
| active_tt | input | 9 | Trap type of the trap being serviced |
| vec_busy | input | 1 | Vector interrupt pending; freezes the outputs |
| irq_req | output | 1 | Level interrupt request to the core |
| irq_tt | output | 9 | Latched trap type of the request |

## Verification
The hardest state to reach is the nested-trap suppression. It needs three things at once: a request already latched at one level, a winner at a different level, and an active trap of the external-interrupt class ranked above that winner. The stimulus table first latches a low level. It then raises a higher level while presenting a higher-ranked external trap at a nonzero trap level, so the outputs must stay on the old value. It then repeats the same setup with a foreign trap class, then with a zero trap level, then with an equal trap type, and each of those must release the update.

// File: rtl/irq_res_pkg.sv
package irq_res_pkg;
  localparam int unsigned TT_W     = 9;
  localparam logic [TT_W-1:0] EXT_BASE = 9'h040;
  localparam int unsigned LVL_N    = 16;
  localparam int unsigned LVL_W    = $clog2(LVL_N);
  localparam int unsigned SOFT_W   = 17;
  localparam int unsigned TICK_BIT = 0;
  localparam int unsigned STICK_BIT = 16;
  localparam int unsigned TIMER_LVL = 14;
  localparam int unsigned TL_W     = 3;

  typedef logic [TT_W-1:0]  tt_t;
  typedef logic [LVL_N-1:0] pend_t;
  typedef logic [LVL_W-1:0] lvl_t;
endpackage

// File: rtl/irq_pend_merge.sv
module irq_pend_merge #(
  parameter int unsigned LVL_N     = 16,
  parameter int unsigned SOFT_W    = 17,
  parameter int unsigned TICK_BIT  = 0,
  parameter int unsigned STICK_BIT = 16,
  parameter int unsigned TIMER_LVL = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LVL_N-1:1]  ext_lvl,
  input  logic [SOFT_W-1:0] sw_pend,
  output logic [LVL_N-1:0]  pend
);
  localparam logic [SOFT_W-1:0] ONE_S    = {{(SOFT_W-1){1'b0}}, 1'b1};
  localparam logic [SOFT_W-1:0] TMR_MASK = (ONE_S << TICK_BIT) | (ONE_S << STICK_BIT);

  logic timer_hit;
  assign timer_hit = |(sw_pend & TMR_MASK);

  for (genvar g = 0; g < LVL_N; g++) begin : g_bit
    logic e_b;
    logic s_b;
    if (g == 0) begin : g_noext
      assign e_b = 1'b0;
    end else begin : g_ext
      assign e_b = ext_lvl[g];
    end
    if (g < SOFT_W) begin : g_sw
      assign s_b = sw_pend[g] & ~TMR_MASK[g];
    end else begin : g_nosw
      assign s_b = 1'b0;
    end
    if (g == TIMER_LVL) begin : g_tmr
      assign pend[g] = e_b | s_b | timer_hit;
    end else begin : g_plain
      assign pend[g] = e_b | s_b;
    end
  end

  AST_EXT_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (pend[LVL_N-1:1] & ext_lvl) == ext_lvl);  // R1
  AST_TIMER_FOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_pend[TICK_BIT] || sw_pend[STICK_BIT]) |-> pend[TIMER_LVL]);  // R2
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
  parameter int unsigned LVL_N = 16,
  parameter int unsigned LVL_W = $clog2(LVL_N)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LVL_N-1:0] pend,
  input  logic [LVL_W-1:0] cur_prio,
  output logic             win_vld,
  output logic [LVL_W-1:0] win_lvl
);
  logic [LVL_N-1:0] above;
  logic [LVL_N-1:0] cand;

  for (genvar g = 0; g < LVL_N; g++) begin : g_above
    assign above[g] = (LVL_W'(g) > cur_prio);
  end
  assign cand = pend & above;

  always_comb begin
    win_vld = 1'b0;
    win_lvl = '0;
    for (int i = 0; i < LVL_N; i++) begin
      if (cand[i]) begin
        win_vld = 1'b1;
        win_lvl = LVL_W'(i);
      end
    end
  end

  AST_WIN_ABOVE: assert property (@(posedge clk) disable iff (!rst_n)
    win_vld |-> (win_lvl > cur_prio));  // R5
  AST_WIN_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    win_vld |-> (LVL_N'(pend >> win_lvl) == LVL_N'(1)));  // R5
endmodule

// File: rtl/irq_nest_gate.sv
module irq_nest_gate #(
  parameter int unsigned TL_W  = 3,
  parameter int unsigned TT_W  = 9,
  parameter int unsigned CLS_LSB = 4,
  parameter logic [TT_W-1:0] EXT_BASE = 9'h040
) (
  input  logic [TL_W-1:0] trap_lvl,
  input  logic [TT_W-1:0] active_tt,
  input  logic [TT_W-1:0] cand_tt,
  output logic            block
);
  logic nested;
  logic same_cls;
  logic ranks_higher;

  assign nested       = |trap_lvl;
  assign same_cls     = (active_tt[TT_W-1:CLS_LSB] == EXT_BASE[TT_W-1:CLS_LSB]);
  assign ranks_higher = (active_tt > cand_tt);
  assign block        = nested & same_cls & ranks_higher;
endmodule

// File: rtl/irq_level_resolver.sv
module irq_level_resolver
  import irq_res_pkg::*;
#(
  parameter int unsigned P_LVL_N     = LVL_N,
  parameter int unsigned P_SOFT_W    = SOFT_W,
  parameter int unsigned P_TICK_BIT  = TICK_BIT,
  parameter int unsigned P_STICK_BIT = STICK_BIT,
  parameter int unsigned P_TIMER_LVL = TIMER_LVL,
  parameter int unsigned P_TL_W      = TL_W,
  parameter int unsigned P_TT_W      = TT_W,
  parameter logic [P_TT_W-1:0] P_EXT_BASE = EXT_BASE
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [P_LVL_N-1:1]    ext_lvl,
  input  logic [P_SOFT_W-1:0]   sw_pend,
  input  logic [$clog2(P_LVL_N)-1:0] cur_prio,
  input  logic                  int_en,
  input  logic [P_TL_W-1:0]     trap_lvl,
  input  logic [P_TT_W-1:0]     active_tt,
  input  logic                  vec_busy,
  output logic                  irq_req,
  output logic [P_TT_W-1:0]     irq_tt
);
  localparam int unsigned L_W   = $clog2(P_LVL_N);
  localparam int unsigned CMP_W = P_LVL_N + 1;

  logic [P_LVL_N-1:0] pend;
  logic               win_vld;
  logic [L_W-1:0]     win_lvl;
  logic [P_TT_W-1:0]  cand_tt;
  logic               block;
  logic [CMP_W-1:0]   thresh;
  logic               below;

  logic               req_q, req_d;
  logic [P_TT_W-1:0]  tt_q, tt_d;
  logic               upd;

  irq_pend_merge #(
    .LVL_N(P_LVL_N), .SOFT_W(P_SOFT_W), .TICK_BIT(P_TICK_BIT),
    .STICK_BIT(P_STICK_BIT), .TIMER_LVL(P_TIMER_LVL)
  ) u_merge (
    .clk(clk), .rst_n(rst_n), .ext_lvl(ext_lvl), .sw_pend(sw_pend), .pend(pend)
  );

  irq_prio_pick #(.LVL_N(P_LVL_N), .LVL_W(L_W)) u_pick (
    .clk(clk), .rst_n(rst_n), .pend(pend), .cur_prio(cur_prio),
    .win_vld(win_vld), .win_lvl(win_lvl)
  );

  assign cand_tt = P_EXT_BASE | P_TT_W'(win_lvl);

  irq_nest_gate #(
    .TL_W(P_TL_W), .TT_W(P_TT_W), .CLS_LSB(L_W), .EXT_BASE(P_EXT_BASE)
  ) u_nest (
    .trap_lvl(trap_lvl), .active_tt(active_tt), .cand_tt(cand_tt), .block(block)
  );

  assign thresh = CMP_W'(2) << cur_prio;
  assign below  = ({1'b0, pend} < thresh);

  // next-state
  always_comb begin
    req_d = req_q;
    tt_d  = tt_q;
    upd   = 1'b0;
    if (!vec_busy) begin
      if (below || !int_en) begin
        req_d = 1'b0;
        tt_d  = '0;
        upd   = 1'b1;
      end else if (win_vld && !block && (cand_tt != tt_q)) begin
        req_d = 1'b1;
        tt_d  = cand_tt;
        upd   = 1'b1;
      end
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q <= 1'b0;
      tt_q  <= '0;
    end else if (upd) begin
      req_q <= req_d;
      tt_q  <= tt_d;
    end
  end

  assign irq_req = req_q;
  assign irq_tt  = tt_q;

  AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    vec_busy |=> ($stable(irq_req) && $stable(irq_tt)));  // R3
  AST_LOW_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (!vec_busy && below) |=> (!irq_req && irq_tt == '0));  // R4
  AST_OFF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (!vec_busy && !int_en) |=> (!irq_req && irq_tt == '0));  // R8
  AST_TT_CLASS: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (irq_tt[P_TT_W-1:L_W] == P_EXT_BASE[P_TT_W-1:L_W] && irq_tt[L_W-1:0] != '0));  // R5
  AST_NEST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!vec_busy && int_en && !below && block) |=> $stable(irq_tt));  // R6
  AST_REQ_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req == (irq_tt != '0));  // R7
endmodule

// File: tb/irq_level_resolver_bench.sv
`timescale 1ns/1ps
module irq_level_resolver_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:1] ext_lvl = '0;
  logic [16:0] sw_pend = '0;
  logic [3:0]  cur_prio = '0;
  logic        int_en = 1'b0;
  logic [2:0]  trap_lvl = '0;
  logic [8:0]  active_tt = '0;
  logic        vec_busy = 1'b0;
  logic        irq_req;
  logic [8:0]  irq_tt;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  irq_level_resolver u_irq_level_resolver (
    .clk(clk), .rst_n(rst_n), .ext_lvl(ext_lvl), .sw_pend(sw_pend),
    .cur_prio(cur_prio), .int_en(int_en), .trap_lvl(trap_lvl),
    .active_tt(active_tt), .vec_busy(vec_busy), .irq_req(irq_req), .irq_tt(irq_tt)
  );

  typedef struct packed {
    logic [15:0] ext;
    logic [16:0] sw;
    logic [3:0]  prio;
    logic        en;
    logic [2:0]  tl;
    logic [8:0]  att;
    logic        busy;
    logic        req;
    logic [8:0]  tt;
    logic [7:0]  rq;
  } vec_t;

  localparam int NV = 24;
  localparam vec_t TBL [NV] = '{
    '{16'h0008, 17'h00000, 4'd0,  1'b1, 3'd0, 9'h000, 1'b0, 1'b1, 9'h043, 8'd5},  // R5 single level
    '{16'h0208, 17'h00000, 4'd0,  1'b1, 3'd0, 9'h000, 1'b0, 1'b1, 9'h049, 8'd5},  // R5 highest wins
    '{16'h0208, 17'h00000, 4'd0,  1'b1, 3'd0, 9'h000, 1'b0, 1'b1, 9'h049, 8'd7},  // R7 same winner
    '{16'h0008, 17'h00000, 4'd0,  1'b1, 3'd0, 9'h000, 1'b0, 1'b1, 9'h043, 8'd7},  // R7 moves down
    '{16'h0000, 17'h00020, 4'd0,  1'b1, 3'd0, 9'h000, 1'b0, 1'b1, 9'h045, 8'd1},  // R1 software level
    '{16'h0000, 17'h00001, 4'd0,  1'b1, 3'd0, 9'h000, 1'b0, 1'b1, 9'h04E, 8'd2},  // R2 tick -> 14
    '{16'h0000, 17'h10000, 4'd0,  1'b1, 3'd0, 9'h000, 1'b0, 1'b1, 9'h04E, 8'd2},  // R2 system tick -> 14
    '{16'h0000, 17'h00001, 4'd14, 1'b1, 3'd0, 9'h000, 1'b0, 1'b0, 9'h000, 8'd4},  // R4 14 not above 14
    '{16'h0010, 17'h00000, 4'd4,  1'b1, 3'd0, 9'h000, 1'b0, 1'b0, 9'h000, 8'd4},  // R4 level at prio
    '{16'h0030, 17'h00000, 4'd4,  1'b1, 3'd0, 9'h000, 1'b0, 1'b1, 9'h045, 8'd5},  // R5 prio boundary
    '{16'h8000, 17'h00000, 4'd4,  1'b1, 3'd0, 9'h000, 1'b1, 1'b1, 9'h045, 8'd3},  // R3 busy hold
    '{16'h8000, 17'h00000, 4'd4,  1'b0, 3'd0, 9'h000, 1'b1, 1'b1, 9'h045, 8'd3},  // R3 busy beats disable
    '{16'h8000, 17'h00000, 4'd4,  1'b0, 3'd0, 9'h000, 1'b0, 1'b0, 9'h000, 8'd8},  // R8 disabled clears
    '{16'h8000, 17'h00000, 4'd15, 1'b1, 3'd0, 9'h000, 1'b0, 1'b0, 9'h000, 8'd11}, // R11 prio 15
    '{16'h0004, 17'h00000, 4'd0,  1'b1, 3'd0, 9'h000, 1'b0, 1'b1, 9'h042, 8'd5},  // R5
    '{16'h0084, 17'h00000, 4'd0,  1'b1, 3'd1, 9'h04A, 1'b0, 1'b1, 9'h042, 8'd6},  // R6 suppressed
    '{16'h0084, 17'h00000, 4'd0,  1'b1, 3'd1, 9'h060, 1'b0, 1'b1, 9'h047, 8'd6},  // R6 other class
    '{16'h0004, 17'h00000, 4'd0,  1'b1, 3'd1, 9'h047, 1'b0, 1'b1, 9'h047, 8'd6},  // R6 lower suppressed
    '{16'h0004, 17'h00000, 4'd0,  1'b1, 3'd0, 9'h047, 1'b0, 1'b1, 9'h042, 8'd6},  // R6 trap level 0
    '{16'h0084, 17'h00000, 4'd0,  1'b1, 3'd2, 9'h047, 1'b0, 1'b1, 9'h047, 8'd6},  // R6 equal type
    '{16'h4000, 17'h00004, 4'd0,  1'b1, 3'd0, 9'h000, 1'b0, 1'b1, 9'h04E, 8'd1},  // R1 merge
    '{16'h0000, 17'h00000, 4'd0,  1'b1, 3'd0, 9'h000, 1'b0, 1'b0, 9'h000, 8'd4},  // R4 nothing pending
    '{16'h0002, 17'h00000, 4'd0,  1'b1, 3'd0, 9'h000, 1'b1, 1'b0, 9'h000, 8'd3},  // R3 hold idle
    '{16'h0002, 17'h00000, 4'd0,  1'b1, 3'd0, 9'h000, 1'b0, 1'b1, 9'h041, 8'd5}   // R5 level 1
  };

  task automatic check(input int rq, input logic er, input logic [8:0] et);
    checks++;
    if (irq_req !== er || irq_tt !== et) begin
      errors++;
      $display("FAIL R%0d: req=%0b tt=%03h expected req=%0b tt=%03h",
               rq, irq_req, irq_tt, er, et);
    end
  endtask

  task automatic apply(input vec_t v);
    ext_lvl   = v.ext[15:1];
    sw_pend   = v.sw;
    cur_prio  = v.prio;
    int_en    = v.en;
    trap_lvl  = v.tl;
    active_tt = v.att;
    vec_busy  = v.busy;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: run did not complete");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check(9, 1'b0, 9'h000);  // R9 reset state
    rst_n = 1'b1;
    @(negedge clk);
    check(9, 1'b0, 9'h000);  // R9 still clear after release, enable low

    for (int i = 0; i < NV; i++) begin
      apply(TBL[i]);
      @(posedge clk);
      @(negedge clk);
      check(int'(TBL[i].rq), TBL[i].req, TBL[i].tt);
    end

    // R9: asynchronous clear while a request is latched (041 from last vector)
    #1 rst_n = 1'b0;
    #0.5 check(9, 1'b0, 9'h000);  // R9 no clock edge yet
    @(negedge clk);
    rst_n = 1'b1;

    // R10: one-cycle latency
    ext_lvl = 15'h4000;  // level 15
    int_en = 1'b1; cur_prio = 4'd0; trap_lvl = '0; active_tt = '0; vec_busy = 1'b0; sw_pend = '0;
    #0.5 check(10, 1'b0, 9'h000);  // R10 unchanged before edge
    @(posedge clk);
    #0.5 check(10, 1'b1, 9'h04F);  // R10 updated after one edge
    @(negedge clk);
    ext_lvl = '0;
    #0.5 check(10, 1'b1, 9'h04F);  // R10 held until next edge
    @(posedge clk);
    #0.5 check(4, 1'b0, 9'h000);   // R4 cleared after edge

    // R2: stick bit alone with prio 13 gives level 14, bit 16 not a level
    @(negedge clk);
    sw_pend = 17'h10000; cur_prio = 4'd13;
    @(posedge clk); @(negedge clk);
    check(2, 1'b1, 9'h04E);
    sw_pend = 17'h00000; ext_lvl = 15'h0000;
    @(posedge clk); @(negedge clk);
    check(4, 1'b0, 9'h000);
    finish_run();
  end
endmodule